// File: doc/BRIEF.md
# NAND Prefetch and Write-Posting Engine

This block streams a programmed number of bytes between a NAND data port and a small byte FIFO. A host or DMA master reads or writes that FIFO one 32-bit word at a time. A single start command selects the mode. In read (prefetch) mode the engine pulls bytes from the NAND port ahead of the host. In write (posting) mode it pushes bytes that the host has deposited out to the NAND port. The same command carries the byte count, a chip-select value and a flag that turns on frame-based DMA requests. Command and address cycles to the flash, and the DMA controller itself, are handled outside this block.

A 32-bit status word always reports two things. The first is how many bytes the host may move now: bytes held in read mode, free space in write mode. The second is how many bytes of the transfer the NAND side still has to move. The engine stays enabled after the count reaches zero. It is released only by a halt command, which also empties it, and any start issued while it is enabled is refused. The NAND port moves `BUS_BYTES` bytes per beat (1 or 2), and each beat waits for the flash side to be ready.

Top module: `nand_pf_engine`

## Requirements
- R1: After reset, status reads zero, busy is low, dma_req is low and neither NAND strobe is active.
- R2: A start while idle takes effect at the next clock. Busy goes high. Status bits 13:0 show the length with its low bits cleared to a multiple of BUS_BYTES (an odd length loses its LSB in 16-bit mode). nand_cs shows the given chip select. start_write picks the direction: 0 is read and 1 is write.
- R3: A start while busy raises start_err for exactly one cycle, one clock later, and leaves the length, direction and chip select unchanged.
- R4: Status bits 30:24 hold the bytes held in the FIFO in read mode, and the free bytes (DEPTH minus held) in write mode. Bits 13:0 hold the remaining count. All other bits read zero.
- R5: In read mode, a NAND read beat occurs only when nand_ready is high, the remaining count is non-zero and at least BUS_BYTES bytes of FIFO space are free. Each beat subtracts BUS_BYTES from the remaining count. The FIFO never holds more than DEPTH bytes.
- R6: In write mode, a NAND write beat occurs only when nand_ready is high, the remaining count is non-zero and the FIFO holds at least BUS_BYTES bytes. Bytes leave in the order the host wrote them, and byte k of a host word is bits 8k+7:8k.
- R7: A host read pops 4 bytes when at least 4 are held. When the remaining count is zero and 1 to 3 bytes are held, it pops those bytes and the unused upper bytes of host_rdata read zero. Any other host read is ignored.
- R8: A host write is taken when at least 4 bytes of FIFO space are free and the host still owes bytes. The last word supplies only the bytes still owed. Writes after that are ignored.
- R9: When the DMA flag was set, dma_req is high in read mode while the FIFO holds a full DEPTH-byte frame. In write mode it is high while the FIFO is empty and the host still owes at least DEPTH bytes. Without the flag it stays low.
- R10: A halt returns the engine to the idle state of R1 at the next clock and empties the FIFO. A halt takes priority over a start in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start command strobe |
| start_len | input | LEN_W | Transfer length in bytes |
| start_write | input | 1 | Direction: 0 read, 1 write |
| start_dma | input | 1 | Enable frame DMA requests |
| start_cs | input | CS_W | Chip select for the transfer |
| halt | input | 1 | Stop and empty the engine |
| busy | output | 1 | Engine enabled |
| start_err | output | 1 | Start refused (one-cycle pulse) |
| status | output | 32 | Available bytes [30:24], remaining bytes [13:0] |
| dma_req | output | 1 | Frame request to the DMA master |
| host_rd | input | 1 | Pop one word from the FIFO |
| host_rdata | output | 32 | Word at the FIFO head |
| host_wr | input | 1 | Push one word into the FIFO |
| host_wdata | input | 32 | Word to push |
| nand_cs | output | CS_W | Latched chip select |
| nand_ready | input | 1 | NAND port can take a beat |
| nand_rd_strobe | output | 1 | Read beat this cycle |
| nand_rdata | input | 8*BUS_BYTES | NAND read data |
| nand_wr_strobe | output | 1 | Write beat this cycle |
| nand_wdata | output | 8*BUS_BYTES | NAND write data |

## Verification
A pointer or count that has drifted shows up first at the host word port. In the next pop, bytes arrive out of order, repeated, or zero where the pattern expects data. The status availability field also departs from the byte count the bench derives from the beats it has seen. A wrong remaining count shows up in status bits 13:0 within one beat. In write mode it shows up as a missing or extra NAND strobe once the FIFO drains. A wrong full or empty test shows up in the same cycle as a request or beat that should not occur.

// File: rtl/nand_pf_pkg.sv
package nand_pf_pkg;

   // Host side word is four byte lanes.
   localparam int HOST_LANES = 4;
   localparam int LANE_NW    = $clog2(HOST_LANES + 1);

   typedef enum logic {
      PF_READ  = 1'b0,
      PF_WRITE = 1'b1
   } pf_dir_e;

   typedef logic [7:0] pf_byte_t;

endpackage

// File: rtl/nand_pf_fifo.sv
module nand_pf_fifo
   import nand_pf_pkg::*;
#(
   parameter int DEPTH = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic [LANE_NW-1:0]         push_n,
   input  logic [8*HOST_LANES-1:0]    push_data,
   input  logic [LANE_NW-1:0]         pop_n,
   output logic [8*HOST_LANES-1:0]    peek_data,
   output logic [$clog2(DEPTH):0]     count
);

   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   pf_byte_t         mem [DEPTH];
   logic [AW-1:0]    wr_ptr;
   logic [AW-1:0]    rd_ptr;

   // One write port and one read tap per byte lane.
   for (genvar g = 0; g < HOST_LANES; g++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!flush && (LANE_NW'(g) < push_n)) begin
            mem[wr_ptr + AW'(g)] <= push_data[8*g +: 8];
         end
      end

      always_comb begin
         if (CW'(g) < count) begin
            peek_data[8*g +: 8] = mem[rd_ptr + AW'(g)];
         end else begin
            peek_data[8*g +: 8] = '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         wr_ptr <= wr_ptr + AW'(push_n);
         rd_ptr <= rd_ptr + AW'(pop_n);
         count  <= count + CW'(push_n) - CW'(pop_n);
      end
   end

endmodule

// File: rtl/nand_pf_ctrl.sv
module nand_pf_ctrl
   import nand_pf_pkg::*;
#(
   parameter int DEPTH     = 64,
   parameter int LEN_W     = 14,
   parameter int CS_W      = 3,
   parameter int BUS_BYTES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [LEN_W-1:0]        start_len,
   input  logic                    start_write,
   input  logic                    start_dma,
   input  logic [CS_W-1:0]         start_cs,
   input  logic                    halt,
   input  logic                    nand_ready,
   input  logic                    host_rd,
   input  logic                    host_wr,
   input  logic [$clog2(DEPTH):0]  fifo_count,
   output logic                    en,
   output pf_dir_e                 dir,
   output logic                    dma_mode,
   output logic [CS_W-1:0]         cs_q,
   output logic [LEN_W-1:0]        remaining,
   output logic [LEN_W-1:0]        host_left,
   output logic                    start_err,
   output logic                    rd_beat,
   output logic                    wr_beat,
   output logic [LANE_NW-1:0]      push_n,
   output logic [LANE_NW-1:0]      pop_n,
   output logic                    flush
);

   localparam int CW = $clog2(DEPTH) + 1;
   localparam logic [LEN_W-1:0] LEN_MASK = ~LEN_W'(BUS_BYTES - 1);

   logic [LEN_W-1:0]   len_eff;
   logic [CW-1:0]      room;
   logic               rem_nz;
   logic               accept;
   logic               host_push;
   logic               host_pop;
   logic [LANE_NW-1:0] host_push_n;
   logic [LANE_NW-1:0] host_pop_n;

   assign len_eff = start_len & LEN_MASK;
   assign room    = CW'(DEPTH) - fifo_count;
   assign rem_nz  = |remaining;
   assign accept  = start & ~en & ~halt;
   assign flush   = halt | accept;

   assign rd_beat = en & (dir == PF_READ) & rem_nz & nand_ready
                  & (room >= CW'(BUS_BYTES));
   assign wr_beat = en & (dir == PF_WRITE) & rem_nz & nand_ready
                  & (fifo_count >= CW'(BUS_BYTES));

   assign host_push   = en & (dir == PF_WRITE) & host_wr & (|host_left)
                      & (room >= CW'(HOST_LANES));
   assign host_push_n = (host_left >= LEN_W'(HOST_LANES)) ? LANE_NW'(HOST_LANES)
                                                         : LANE_NW'(host_left);

   assign host_pop    = en & (dir == PF_READ) & host_rd
                      & ((fifo_count >= CW'(HOST_LANES)) | (~rem_nz & (|fifo_count)));
   assign host_pop_n  = (fifo_count >= CW'(HOST_LANES)) ? LANE_NW'(HOST_LANES)
                                                       : LANE_NW'(fifo_count);

   always_comb begin
      push_n = '0;
      pop_n  = '0;
      if (rd_beat) begin
         push_n = LANE_NW'(BUS_BYTES);
      end else if (host_push) begin
         push_n = host_push_n;
      end
      if (wr_beat) begin
         pop_n = LANE_NW'(BUS_BYTES);
      end else if (host_pop) begin
         pop_n = host_pop_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en        <= 1'b0;
         dir       <= PF_READ;
         dma_mode  <= 1'b0;
         cs_q      <= '0;
         remaining <= '0;
         host_left <= '0;
         start_err <= 1'b0;
      end else begin
         start_err <= start & en & ~halt;
         if (halt) begin
            en        <= 1'b0;
            remaining <= '0;
            host_left <= '0;
         end else if (accept) begin
            en        <= 1'b1;
            dir       <= pf_dir_e'(start_write);
            dma_mode  <= start_dma;
            cs_q      <= start_cs;
            remaining <= len_eff;
            host_left <= start_write ? len_eff : '0;
         end else begin
            if (rd_beat || wr_beat) begin
               remaining <= remaining - LEN_W'(BUS_BYTES);
            end
            if (host_push) begin
               host_left <= host_left - LEN_W'(host_push_n);
            end
         end
      end
   end

endmodule

// File: rtl/nand_pf_dma.sv
module nand_pf_dma
   import nand_pf_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int LEN_W = 14
) (
   input  logic                    en,
   input  pf_dir_e                 dir,
   input  logic                    dma_mode,
   input  logic [$clog2(DEPTH):0]  fifo_count,
   input  logic [LEN_W-1:0]        host_left,
   output logic                    dma_req
);

   localparam int CW = $clog2(DEPTH) + 1;

   logic frame_in;
   logic frame_out;

   // A full frame is ready to read, or an empty FIFO can take a whole frame.
   assign frame_in  = (fifo_count == CW'(DEPTH));
   assign frame_out = (fifo_count == '0) & (host_left >= LEN_W'(DEPTH));

   assign dma_req = en & dma_mode & ((dir == PF_WRITE) ? frame_out : frame_in);

endmodule

// File: rtl/nand_pf_engine.sv
module nand_pf_engine
   import nand_pf_pkg::*;
#(
   parameter int DEPTH     = 64,
   parameter int LEN_W     = 14,
   parameter int CS_W      = 3,
   parameter int BUS_BYTES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [LEN_W-1:0]         start_len,
   input  logic                     start_write,
   input  logic                     start_dma,
   input  logic [CS_W-1:0]          start_cs,
   input  logic                     halt,
   output logic                     busy,
   output logic                     start_err,
   output logic [31:0]              status,
   output logic                     dma_req,
   input  logic                     host_rd,
   output logic [31:0]              host_rdata,
   input  logic                     host_wr,
   input  logic [31:0]              host_wdata,
   output logic [CS_W-1:0]          nand_cs,
   input  logic                     nand_ready,
   output logic                     nand_rd_strobe,
   input  logic [8*BUS_BYTES-1:0]   nand_rdata,
   output logic                     nand_wr_strobe,
   output logic [8*BUS_BYTES-1:0]   nand_wdata
);

   localparam int CW     = $clog2(DEPTH) + 1;
   localparam int AVAIL0 = 24;

   // Elaboration-time parameter checks.
   if (BUS_BYTES != 1 && BUS_BYTES != 2) begin : g_bad_bus
      $error("BUS_BYTES must be 1 or 2");
   end
   if ((1 << $clog2(DEPTH)) != DEPTH || DEPTH < 2 * HOST_LANES) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 8");
   end
   if (CW > 7) begin : g_bad_avail
      $error("DEPTH does not fit the 7-bit availability field");
   end
   if (LEN_W > 14 || LEN_W < CW) begin : g_bad_len
      $error("LEN_W must lie between the count width and 14");
   end

   logic                       en;
   pf_dir_e                    dir;
   logic                       dma_mode;
   logic [LEN_W-1:0]           remaining;
   logic [LEN_W-1:0]           host_left;
   logic                       rd_beat;
   logic                       wr_beat;
   logic [LANE_NW-1:0]         push_n;
   logic [LANE_NW-1:0]         pop_n;
   logic                       flush;
   logic [CW-1:0]              fifo_count;
   logic [8*HOST_LANES-1:0]    push_data;
   logic [8*HOST_LANES-1:0]    peek_data;
   logic [CW-1:0]              avail;

   nand_pf_ctrl #(
      .DEPTH     (DEPTH),
      .LEN_W     (LEN_W),
      .CS_W      (CS_W),
      .BUS_BYTES (BUS_BYTES)
   ) i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .start_len   (start_len),
      .start_write (start_write),
      .start_dma   (start_dma),
      .start_cs    (start_cs),
      .halt        (halt),
      .nand_ready  (nand_ready),
      .host_rd     (host_rd),
      .host_wr     (host_wr),
      .fifo_count  (fifo_count),
      .en          (en),
      .dir         (dir),
      .dma_mode    (dma_mode),
      .cs_q        (nand_cs),
      .remaining   (remaining),
      .host_left   (host_left),
      .start_err   (start_err),
      .rd_beat     (rd_beat),
      .wr_beat     (wr_beat),
      .push_n      (push_n),
      .pop_n       (pop_n),
      .flush       (flush)
   );

   // Push source: NAND lanes in read mode, host word in write mode.
   if (BUS_BYTES == HOST_LANES) begin : g_push_full
      assign push_data = (dir == PF_WRITE) ? host_wdata : nand_rdata;
   end else begin : g_push_narrow
      assign push_data = (dir == PF_WRITE) ? host_wdata
                       : {{(8*(HOST_LANES-BUS_BYTES)){1'b0}}, nand_rdata};
   end

   nand_pf_fifo #(
      .DEPTH (DEPTH)
   ) i_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .push_n    (push_n),
      .push_data (push_data),
      .pop_n     (pop_n),
      .peek_data (peek_data),
      .count     (fifo_count)
   );

   nand_pf_dma #(
      .DEPTH (DEPTH),
      .LEN_W (LEN_W)
   ) i_dma (
      .en         (en),
      .dir        (dir),
      .dma_mode   (dma_mode),
      .fifo_count (fifo_count),
      .host_left  (host_left),
      .dma_req    (dma_req)
   );

   assign busy           = en;
   assign nand_rd_strobe = rd_beat;
   assign nand_wr_strobe = wr_beat;
   assign nand_wdata     = peek_data[8*BUS_BYTES-1:0];
   assign host_rdata     = (en && dir == PF_READ) ? peek_data : '0;

   always_comb begin
      if (!en) begin
         avail = '0;
      end else if (dir == PF_WRITE) begin
         avail = CW'(DEPTH) - fifo_count;
      end else begin
         avail = fifo_count;
      end
   end

   always_comb begin
      status                  = '0;
      status[AVAIL0 +: CW]    = avail;
      status[LEN_W-1:0]       = remaining;
   end

endmodule

// File: rtl/nand_pf_engine_chk.sv
module nand_pf_engine_chk #(
   parameter int DEPTH = 64
) (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic        halt,
   input logic        nand_ready,
   input logic        busy,
   input logic        start_err,
   input logic        dma_req,
   input logic        nand_rd_strobe,
   input logic        nand_wr_strobe,
   input logic [31:0] status
);

   // R4
   avail_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status[30:24] <= 7'(DEPTH));

   // R5
   rd_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nand_rd_strobe |-> (nand_ready && busy && !nand_wr_strobe));

   // R6
   wr_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nand_wr_strobe |-> (nand_ready && busy));

   // R3
   start_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_err |-> ($past(busy) && $past(start)));

   // R2
   start_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !halt) |=> busy);

   // R10
   halt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> (!busy && status == 32'd0 && !dma_req));

   // R9
   dma_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> busy);

   // R5
   rem_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !halt) |=> (status[13:0] <= $past(status[13:0])));

endmodule

bind nand_pf_engine nand_pf_engine_chk #(.DEPTH(DEPTH)) i_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .start          (start),
   .halt           (halt),
   .nand_ready     (nand_ready),
   .busy           (busy),
   .start_err      (start_err),
   .dma_req        (dma_req),
   .nand_rd_strobe (nand_rd_strobe),
   .nand_wr_strobe (nand_wr_strobe),
   .status         (status)
);

// File: tb/test_nand_pf_engine.sv
`timescale 1ns/1ps
module test_nand_pf_engine;

   localparam int DEPTH = 64;
   localparam int LEN_W = 14;
   localparam int CS_W  = 3;
   localparam int BB    = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [LEN_W-1:0]  start_len = '0;
   logic              start_write = 1'b0;
   logic              start_dma = 1'b0;
   logic [CS_W-1:0]   start_cs = '0;
   logic              halt = 1'b0;
   logic              busy;
   logic              start_err;
   logic [31:0]       status;
   logic              dma_req;
   logic              host_rd = 1'b0;
   logic [31:0]       host_rdata;
   logic              host_wr = 1'b0;
   logic [31:0]       host_wdata = '0;
   logic [CS_W-1:0]   nand_cs;
   logic              nand_ready = 1'b0;
   logic              nand_rd_strobe;
   logic [8*BB-1:0]   nand_rdata;
   logic              nand_wr_strobe;
   logic [8*BB-1:0]   nand_wdata;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int src_bytes = 0;
   int src_base = 0;
   int wcnt = 0;
   logic [7:0] wcap [1024];

   always #5 clk = ~clk;

   nand_pf_engine #(
      .DEPTH (DEPTH), .LEN_W (LEN_W), .CS_W (CS_W), .BUS_BYTES (BB)
   ) i_nand_pf_engine (
      .clk (clk), .rst_n (rst_n), .start (start), .start_len (start_len),
      .start_write (start_write), .start_dma (start_dma), .start_cs (start_cs),
      .halt (halt), .busy (busy), .start_err (start_err), .status (status),
      .dma_req (dma_req), .host_rd (host_rd), .host_rdata (host_rdata),
      .host_wr (host_wr), .host_wdata (host_wdata), .nand_cs (nand_cs),
      .nand_ready (nand_ready), .nand_rd_strobe (nand_rd_strobe),
      .nand_rdata (nand_rdata), .nand_wr_strobe (nand_wr_strobe),
      .nand_wdata (nand_wdata)
   );

   function automatic logic [7:0] rpat(input int i);
      return 8'((i * 37 + 5) & 255);
   endfunction

   function automatic logic [7:0] wpat(input int i);
      return 8'((i * 11 + 1) & 255);
   endfunction

   // NAND source model: byte stream indexed from the current transfer start.
   assign nand_rdata = {rpat(src_bytes - src_base + 1), rpat(src_bytes - src_base)};

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (nand_rd_strobe) src_bytes <= src_bytes + BB;
      if (nand_wr_strobe) begin
         wcap[wcnt]     <= nand_wdata[7:0];
         wcap[wcnt + 1] <= nand_wdata[15:8];
         wcnt           <= wcnt + BB;
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cycles > 150000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
         summary();
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic begin_xfer(input int len, input logic wr, input logic dma, input int cs);
      @(negedge clk);
      src_base    = src_bytes;
      start       = 1'b1;
      start_len   = LEN_W'(len);
      start_write = wr;
      start_dma   = dma;
      start_cs    = CS_W'(cs);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic do_halt();
      @(negedge clk);
      halt = 1'b1;
      @(negedge clk);
      halt = 1'b0;
   endtask

   task automatic wait_avail4();
      while (!(status[30:24] >= 7'd4 || (status[13:0] == 0 && status[30:24] != 0)))
         @(negedge clk);
   endtask

   // Check the head word for stream bytes k..k+n-1, then pop it.
   task automatic pop_expect(input string req, input int k, input int n);
      logic [31:0] exp;
      exp = '0;
      for (int j = 0; j < 4; j++) if (j < n) exp[8*j +: 8] = rpat(k + j);
      check(req, host_rdata, exp);
      host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic write_run(input int len);
      int base;
      int pushed;
      logic [31:0] w;
      do_halt();
      base = wcnt;
      begin_xfer(len, 1'b1, 1'b1, 2);
      check("R4 write free space", 32'(status[30:24]), 32'(DEPTH));
      check("R9 write frame request", 32'(dma_req), 32'(len >= DEPTH));
      pushed = 0;
      while (pushed < len) begin
         while (status[30:24] < 7'd4) @(negedge clk);
         for (int j = 0; j < 4; j++) w[8*j +: 8] = wpat(pushed + j);
         host_wr = 1'b1;
         host_wdata = w;
         @(negedge clk);
         host_wr = 1'b0;
         pushed = pushed + 4;
      end
      host_wr = 1'b1;
      host_wdata = 32'hDEADBEEF;
      @(negedge clk);
      host_wr = 1'b0;
      cyc(80);
      check("R6 write remaining zero", 32'(status[13:0]), 32'd0);
      check("R8 bytes drained equal length", 32'(wcnt - base), 32'(len));
      for (int i = 0; i < len; i++)
         check("R6 drained byte order", 32'(wcap[base + i]), 32'(wpat(i)));
      check("R8 extra write ignored, FIFO empty", 32'(status[30:24]), 32'(DEPTH));
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      check("R1 status", status, 32'd0);
      check("R1 busy", 32'(busy), 32'd0);
      check("R1 dma_req", 32'(dma_req), 32'd0);
      check("R1 strobes", {30'd0, nand_rd_strobe, nand_wr_strobe}, 32'd0);

      // R2 odd length with NAND stalled
      nand_ready = 1'b0;
      begin_xfer(7, 1'b0, 1'b0, 5);
      check("R2 busy", 32'(busy), 32'd1);
      check("R2 rounded length", 32'(status[13:0]), 32'd6);
      check("R2 chip select", 32'(nand_cs), 32'd5);
      check("R4 read avail empty", 32'(status[30:24]), 32'd0);
      check("R5 no beat while not ready", 32'(nand_rd_strobe), 32'd0);
      cyc(3);
      check("R5 remaining held", 32'(status[13:0]), 32'd6);

      // R3 start while busy
      @(negedge clk);
      start = 1'b1; start_len = 14'd20; start_write = 1'b1; start_cs = 3'd1;
      @(negedge clk);
      start = 1'b0;
      check("R3 start_err pulse", 32'(start_err), 32'd1);
      check("R3 length kept", 32'(status[13:0]), 32'd6);
      check("R3 cs kept", 32'(nand_cs), 32'd5);
      @(negedge clk);
      check("R3 pulse one cycle", 32'(start_err), 32'd0);

      // R10 halt
      do_halt();
      check("R10 status cleared", status, 32'd0);
      check("R10 busy low", 32'(busy), 32'd0);
      // R10 halt beats start in same cycle
      @(negedge clk);
      start = 1'b1; halt = 1'b1; start_len = 14'd8; start_write = 1'b0;
      @(negedge clk);
      start = 1'b0; halt = 1'b0;
      check("R10 halt priority", 32'(busy), 32'd0);
      check("R10 no start_err", 32'(start_err), 32'd0);

      // R5 R7 read sweep over lengths
      nand_ready = 1'b1;
      for (int len = 2; len <= DEPTH; len += 2) begin
         do_halt();
         begin_xfer(len, 1'b0, 1'b0, len % 8);
         cyc(40);
         check("R5 remaining zero", 32'(status[13:0]), 32'd0);
         check("R4 avail equals length", 32'(status[30:24]), 32'(len));
         check("R5 beats taken", 32'(src_bytes - src_base), 32'(len));
         check("R9 no request without flag", 32'(dma_req), 32'd0);
         for (int k = 0; k < len; k += 4)
            pop_expect("R7 read word", k, (len - k) < 4 ? (len - k) : 4);
         check("R7 drained", 32'(status[30:24]), 32'd0);
         host_rd = 1'b1;
         @(negedge clk);
         host_rd = 1'b0;
         check("R7 empty pop ignored", 32'(status[30:24]), 32'd0);
      end

      // R9 read DMA frames, FIFO fill limit
      do_halt();
      begin_xfer(128, 1'b0, 1'b1, 3);
      cyc(40);
      check("R5 fill stops at depth", 32'(status[30:24]), 32'(DEPTH));
      check("R5 remaining after fill", 32'(status[13:0]), 32'd64);
      check("R9 read frame request", 32'(dma_req), 32'd1);
      pop_expect("R7 first word", 0, 4);
      check("R9 request drops after pop", 32'(dma_req), 32'd0);
      for (int k = 4; k < 128; k += 4) begin
         wait_avail4();
         pop_expect("R7 streamed word", k, 4);
      end
      check("R5 read done", 32'(status[13:0]), 32'd0);

      // R6 write only drains when data present
      do_halt();
      begin_xfer(20, 1'b1, 1'b0, 4);
      cyc(10);
      check("R6 no drain when empty", 32'(status[13:0]), 32'd20);
      nand_ready = 1'b0;
      for (int j = 0; j < 2; j++) begin
         host_wr = 1'b1;
         host_wdata = 32'h0403_0201 + 32'(j);
         @(negedge clk);
      end
      host_wr = 1'b0;
      cyc(5);
      check("R6 no drain when not ready", 32'(status[13:0]), 32'd20);
      check("R8 free after pushes", 32'(status[30:24]), 32'd56);
      nand_ready = 1'b1;
      cyc(10);
      check("R6 drained pushed bytes", 32'(status[13:0]), 32'd12);
      check("R4 free restored", 32'(status[30:24]), 32'(DEPTH));

      // R6 R8 R9 write sweep
      write_run(4);
      write_run(6);
      write_run(10);
      write_run(64);
      write_run(100);
      write_run(130);

      do_halt();
      check("R1 idle at end", status, 32'd0);
      summary();
   end

endmodule